// File: doc/BRIEF.md
# Configurable Microcontroller Bus Slave Interface

This block sits between an 8-bit microcontroller bus and the memories and registers inside a chip. Static configuration inputs select the bus style. In the multiplexed style, one bidirectional 8-bit port carries the low address byte and then the data. An address strobe captures that byte. In the separate style, the same port carries only the low address, and data moves on its own 8-bit port. A high-address byte port and a few extension bits make up the rest of the address, so the system address can be wider than 16 bits.

Three control conventions can be selected: separate active-low read and write strobes, a read/write level qualified by a high-true enable, and a read/write level qualified by an active-low data strobe. With the separate-strobe convention, an optional program-fetch strobe can also act as a read. The block decodes the strobes into a combinational read request and a one-cycle registered write pulse. It compares the full address against a base/size window and drives read data onto the active port only during a selected read.

Top module: `mcu_bus_if`

## Requirements
- R1: With cfg_muxed=1, the low address byte follows ad_in while ale is high. On each clock with ale high that value is stored, and it is held while ale is low.
- R2: With cfg_muxed=0, the low address byte is ad_in itself and ale has no effect on it.
- R3: addr_out is {ext_addr, hi_addr, low byte}, which is 20 bits by default. The window is selected when WIN_BASE <= addr_out < WIN_BASE+WIN_SIZE, which is 0x01000 to 0x02FFF by default.
- R4: A read in the window drives mem_rdata on ad_out with ad_oe=1 when multiplexed, or on dp_out with dp_oe=1 when separate. Otherwise both enables are 0, and mem_re is 1 exactly when a read is in the window.
- R5: cfg_conv=0 selects separate strobes. ctl0 low is a write and ctl1 low is a read.
- R6: With cfg_conv=0 and cfg_fetch_en=1, ctl2 low is also a read. With cfg_fetch_en=0, or in any other convention, ctl2 has no effect.
- R7: cfg_conv=1 selects R/W with enable. ctl1 high enables the cycle, and ctl0 high means read while ctl0 low means write.
- R8: cfg_conv=2 selects R/W with data strobe. ctl1 low enables the cycle, and ctl0 has the same meaning as in R7. cfg_conv=3 decodes neither a read nor a write.
- R9: At the first clock edge where a write is decoded with the window selected, mem_waddr and mem_wdata are captured. The write data comes from ad_in when multiplexed and from dp_in when separate. mem_we is high for the one following cycle only, even if the write is held.
- R10: Neither port is driven while a write is decoded (this includes ctl0 and ctl1 both low under cfg_conv=0), and the two ports are never driven together.
- R11: After synchronous reset, mem_we is 0 and the stored low address byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_muxed | input | 1 | 1 selects the multiplexed style, 0 selects the separate style |
| cfg_conv | input | 2 | Control convention select |
| cfg_fetch_en | input | 1 | Enables the program-fetch strobe on ctl2 |
| ctl0 | input | 1 | Write strobe (active low) or R/W level |
| ctl1 | input | 1 | Read strobe (active low), enable, or data strobe |
| ctl2 | input | 1 | Program-fetch strobe, active low |
| ale | input | 1 | Address strobe, high-true |
| ad_in | input | 8 | Shared or address port, input side |
| ad_out | output | 8 | Shared port read data |
| ad_oe | output | 1 | Shared port drive enable |
| dp_in | input | 8 | Separate data port, input side |
| dp_out | output | 8 | Separate data port read data |
| dp_oe | output | 1 | Separate data port drive enable |
| hi_addr | input | 8 | High address byte |
| ext_addr | input | 4 | Address extension bits |
| addr_out | output | 20 | Effective (latched) address |
| mem_re | output | 1 | Internal read request |
| mem_rdata | input | 8 | Internal read data |
| mem_we | output | 1 | Internal write pulse |
| mem_waddr | output | 20 | Write address |
| mem_wdata | output | 8 | Write data |

## Verification
The drive enables, addr_out and mem_re are combinational from the pins and the stored byte. The bench therefore checks them 1 ns after it changes the strobes, within the same cycle. mem_we, mem_waddr and mem_wdata appear one clock edge after a write is first decoded. The bench samples them at the next falling edge and checks one cycle later that mem_we has dropped while the write is still held. The stored address byte takes effect at the clock edge where ale is high. It is therefore tested half a cycle after ale falls, with ad_in already changed.

// File: rtl/mbi_pkg.sv
package mbi_pkg;

    typedef enum logic [1:0] {
        CONV_RDWR  = 2'd0,
        CONV_RW_E  = 2'd1,
        CONV_RW_DS = 2'd2,
        CONV_NONE  = 2'd3
    } conv_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    // Turn the raw control pins into read/write requests for one convention.
    function automatic strobe_t decode_strobes(conv_e conv, logic fetch_en,
                                               logic c0, logic c1, logic c2);
        strobe_t s;
        s = '0;
        case (conv)
            CONV_RDWR: begin
                s.wr = ~c0;
                s.rd = ~c1 | (fetch_en & ~c2);
            end
            CONV_RW_E: begin
                s.rd = c1 & c0;
                s.wr = c1 & ~c0;
            end
            CONV_RW_DS: begin
                s.rd = ~c1 & c0;
                s.wr = ~c1 & ~c0;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mbi_addr_path.sv
module mbi_addr_path #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HI_W     = 8,
    parameter int unsigned EXT_W    = 4,
    parameter int unsigned WIN_BASE = 32'h0000_1000,
    parameter int unsigned WIN_SIZE = 32'h0000_2000,
    localparam int unsigned FULL_W  = DATA_W + HI_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              muxed,
    input  logic              ale,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [HI_W-1:0]   hi_addr,
    input  logic [EXT_W-1:0]  ext_addr,
    output logic [FULL_W-1:0] addr,
    output logic              sel
);
    logic [DATA_W-1:0] held_q;
    logic [DATA_W-1:0] lo;
    logic [31:0]       a32;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (muxed && ale)
            held_q <= ad_in;
    end

    always_comb begin
        if (!muxed || ale)
            lo = ad_in;
        else
            lo = held_q;
        addr = {ext_addr, hi_addr, lo};
        a32  = 32'(addr);
        sel  = (a32 >= WIN_BASE) && ((a32 - WIN_BASE) < WIN_SIZE);
    end

    // R1
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (muxed && !ale && $past(muxed) && $past(!ale) && !$past(rst))
        |-> $stable(addr[DATA_W-1:0]) || !$stable(hi_addr) || !$stable(ext_addr)
            || $stable(addr));

endmodule

// File: rtl/mbi_strobe_dec.sv
module mbi_strobe_dec
    import mbi_pkg::*;
(
    input  conv_e conv,
    input  logic  fetch_en,
    input  logic  ctl0,
    input  logic  ctl1,
    input  logic  ctl2,
    output logic  rd_act,
    output logic  wr_act
);
    strobe_t s;

    always_comb begin
        s      = decode_strobes(conv, fetch_en, ctl0, ctl1, ctl2);
        wr_act = s.wr;
        rd_act = s.rd & ~s.wr;
    end

endmodule

// File: rtl/mbi_wr_capture.sv
module mbi_wr_capture #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_act,
    input  logic              sel,
    input  logic              muxed,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [DATA_W-1:0] dp_in,
    input  logic [ADDR_W-1:0] addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q      <= 1'b0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            wr_q   <= wr_act;
            mem_we <= wr_act & ~wr_q & sel;
            if (wr_act && !wr_q) begin
                mem_waddr <= addr;
                mem_wdata <= muxed ? ad_in : dp_in;
            end
        end
    end

    // R9
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R9
    we_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(wr_act) && $past(sel));

endmodule

// File: rtl/mcu_bus_if.sv
module mcu_bus_if
    import mbi_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HI_W     = 8,
    parameter int unsigned EXT_W    = 4,
    parameter int unsigned WIN_BASE = 32'h0000_1000,
    parameter int unsigned WIN_SIZE = 32'h0000_2000,
    localparam int unsigned FULL_W  = DATA_W + HI_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_muxed,
    input  logic [1:0]        cfg_conv,
    input  logic              cfg_fetch_en,
    input  logic              ctl0,
    input  logic              ctl1,
    input  logic              ctl2,
    input  logic              ale,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] dp_in,
    output logic [DATA_W-1:0] dp_out,
    output logic              dp_oe,
    input  logic [HI_W-1:0]   hi_addr,
    input  logic [EXT_W-1:0]  ext_addr,
    output logic [FULL_W-1:0] addr_out,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [FULL_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic sel;
    logic rd_act;
    logic wr_act;

    mbi_addr_path #(
        .DATA_W(DATA_W), .HI_W(HI_W), .EXT_W(EXT_W),
        .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
    ) addr_i (
        .clk(clk), .rst(rst), .muxed(cfg_muxed), .ale(ale),
        .ad_in(ad_in), .hi_addr(hi_addr), .ext_addr(ext_addr),
        .addr(addr_out), .sel(sel)
    );

    mbi_strobe_dec dec_i (
        .conv(conv_e'(cfg_conv)), .fetch_en(cfg_fetch_en),
        .ctl0(ctl0), .ctl1(ctl1), .ctl2(ctl2),
        .rd_act(rd_act), .wr_act(wr_act)
    );

    mbi_wr_capture #(.DATA_W(DATA_W), .ADDR_W(FULL_W)) wr_i (
        .clk(clk), .rst(rst), .wr_act(wr_act), .sel(sel), .muxed(cfg_muxed),
        .ad_in(ad_in), .dp_in(dp_in), .addr(addr_out),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    always_comb begin
        mem_re = rd_act & sel;
        ad_oe  = mem_re & cfg_muxed;
        dp_oe  = mem_re & ~cfg_muxed;
        ad_out = mem_rdata;
        dp_out = mem_rdata;
    end

    // R10
    no_dual_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !(ad_oe && dp_oe));

    // R10
    write_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (ad_oe || dp_oe) |-> ctl0);

    // R4
    ad_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> cfg_muxed && mem_re);

    // R4
    dp_mode_chk: assert property (@(posedge clk) disable iff (rst)
        dp_oe |-> !cfg_muxed && mem_re);

endmodule

// File: tb/mcu_bus_if_tb_top.sv
module mcu_bus_if_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_muxed, cfg_fetch_en;
    logic [1:0]  cfg_conv;
    logic        ctl0, ctl1, ctl2, ale;
    logic [7:0]  ad_in, ad_out, dp_in, dp_out, hi_addr, mem_rdata, mem_wdata;
    logic        ad_oe, dp_oe, mem_re, mem_we;
    logic [3:0]  ext_addr;
    logic [19:0] addr_out, mem_waddr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mcu_bus_if dut_i (
        .clk(clk), .rst(rst), .cfg_muxed(cfg_muxed), .cfg_conv(cfg_conv),
        .cfg_fetch_en(cfg_fetch_en), .ctl0(ctl0), .ctl1(ctl1), .ctl2(ctl2),
        .ale(ale), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .dp_in(dp_in), .dp_out(dp_out), .dp_oe(dp_oe), .hi_addr(hi_addr),
        .ext_addr(ext_addr), .addr_out(addr_out), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    assign mem_rdata = addr_out[7:0] ^ 8'hA5;

    typedef struct packed {
        logic [23:0] tag;
        logic        muxed;
        logic [1:0]  conv;
        logic        fetch;
        logic        c0, c1, c2;
        logic [19:0] addr;
        logic        exp_rd;
        logic        exp_wr;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{"R5",  1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h01234, 1'b1, 1'b0},
        '{"R3",  1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h05234, 1'b0, 1'b0},
        '{"R5",  1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h01256, 1'b0, 1'b1},
        '{"R6",  1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 20'h01278, 1'b1, 1'b0},
        '{"R6",  1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h01278, 1'b0, 1'b0},
        '{"R4",  1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h0129A, 1'b1, 1'b0},
        '{"R9",  1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h012BC, 1'b0, 1'b1},
        '{"R7",  1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 20'h02001, 1'b1, 1'b0},
        '{"R7",  1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 20'h02002, 1'b0, 1'b1},
        '{"R6",  1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 20'h02003, 1'b0, 1'b0},
        '{"R8",  1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 20'h02104, 1'b1, 1'b0},
        '{"R8",  1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 20'h02105, 1'b0, 1'b1},
        '{"R8",  1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 20'h02106, 1'b0, 1'b0},
        '{"R10", 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 20'h01307, 1'b0, 1'b1},
        '{"R10", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 20'h01308, 1'b0, 1'b1},
        '{"R3",  1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h11234, 1'b0, 1'b0},
        '{"R3",  1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h02FFF, 1'b1, 1'b0},
        '{"R3",  1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h03000, 1'b0, 1'b0},
        '{"R3",  1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h01000, 1'b1, 1'b0},
        '{"R3",  1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h00FFF, 1'b0, 1'b0},
        '{"R8",  1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 20'h01400, 1'b0, 1'b0},
        '{"R9",  1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h04400, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_idle(input logic [1:0] conv);
        ctl0 = 1'b1;
        ctl1 = (conv == 2'd1) ? 1'b0 : 1'b1;
        ctl2 = 1'b1;
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        logic [7:0] wd;
        tag = $sformatf("%s", v.tag);
        wd  = v.addr[7:0] ^ 8'h3C;
        @(negedge clk);
        cfg_muxed = v.muxed; cfg_conv = v.conv; cfg_fetch_en = v.fetch;
        set_idle(v.conv);
        ale = v.muxed; ad_in = v.addr[7:0];
        hi_addr = v.addr[15:8]; ext_addr = v.addr[19:16]; dp_in = 8'h00;
        @(negedge clk);
        ale = 1'b0;
        if (v.muxed) ad_in = wd; else dp_in = wd;
        ctl0 = v.c0; ctl1 = v.c1; ctl2 = v.c2;
        #1;
        check(tag, 32'(addr_out), 32'(v.addr));
        check(tag, 32'(ad_oe), 32'(v.exp_rd & v.muxed));
        check(tag, 32'(dp_oe), 32'(v.exp_rd & ~v.muxed));
        check(tag, 32'(mem_re), 32'(v.exp_rd));
        if (v.exp_rd)
            check(tag, 32'(v.muxed ? ad_out : dp_out), 32'(v.addr[7:0] ^ 8'hA5));
        @(negedge clk);
        check(tag, 32'(mem_we), 32'(v.exp_wr));
        if (v.exp_wr) begin
            check(tag, 32'(mem_waddr), 32'(v.addr));
            check(tag, 32'(mem_wdata), 32'(wd));
        end
        @(negedge clk);
        check(tag, 32'(mem_we), 32'd0);
        set_idle(v.conv);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_muxed = 1'b1; cfg_conv = 2'd0; cfg_fetch_en = 1'b0;
        ctl0 = 1'b1; ctl1 = 1'b1; ctl2 = 1'b1; ale = 1'b0;
        ad_in = 8'h00; dp_in = 8'h00; hi_addr = 8'h00; ext_addr = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        check("R11", 32'(mem_we), 32'd0);
        check("R11", 32'(addr_out), 32'd0);
        check("R11", 32'(ad_oe | dp_oe), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: transparent while ale high, held after it falls
        @(negedge clk);
        cfg_muxed = 1'b1; cfg_conv = 2'd0; set_idle(2'd0);
        hi_addr = 8'h00; ext_addr = 4'h0;
        ale = 1'b1; ad_in = 8'h11;
        #1 check("R1", 32'(addr_out[7:0]), 32'h11);
        @(negedge clk);
        ale = 1'b0; ad_in = 8'h22;
        #1 check("R1", 32'(addr_out[7:0]), 32'h11);
        @(negedge clk);
        ad_in = 8'h33;
        #1 check("R1", 32'(addr_out[7:0]), 32'h11);

        // R2: ale has no effect in separate mode
        @(negedge clk);
        cfg_muxed = 1'b0; ale = 1'b1; ad_in = 8'h56;
        #1 check("R2", 32'(addr_out[7:0]), 32'h56);
        @(negedge clk);
        ale = 1'b0; ad_in = 8'h78;
        #1 check("R2", 32'(addr_out[7:0]), 32'h78);

        // R11: reset clears the stored byte
        @(negedge clk);
        cfg_muxed = 1'b1; ale = 1'b1; ad_in = 8'h9C;
        @(negedge clk);
        ale = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; ad_in = 8'hFF;
        #1 check("R11", 32'(addr_out[7:0]), 32'h00);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule